// File: doc/BRIEF.md
# RV64 Main Control Decoder

This block turns the 7-bit major opcode of an RV64 instruction into the control fields that steer a single-cycle datapath. These fields select whether and how the ALU is used, whether the operation is register-register or register-immediate, whether it works on 32-bit or 64-bit data, what kind of jump it is, what kind of memory access it makes, where each ALU operand comes from, and which value is written back to the register file. A flag marks whether the opcode was recognised.

The decoder is purely combinational and holds no state. It sits between instruction fetch and the datapath multiplexers. Finer decoding on funct3 and funct7 is left to other units.

When a field does not matter for an opcode, the decoder still drives it to zero. Every output therefore has exactly one defined value for each of the 128 opcodes.

Top module: `rv64_main_decode`

## Requirements
- R1: An opcode outside the eleven listed below drives every output to zero, including `inst_ok`.
- R2: Opcodes 0110011 and 0111011 give `alu_use`=1, `wb_sel`=1 and `inst_ok`=1. Opcode 0111011 also gives `word_op`=1. All other fields are 0.
- R3: Opcodes 0010011 and 0011011 give `alu_use`=1, `imm_arith`=1, `opb_sel`=1, `wb_sel`=1 and `inst_ok`=1. Opcode 0011011 also gives `word_op`=1.
- R4: Opcode 0000011 (load) gives `alu_use`=2, `mem_kind`=1, `opb_sel`=1, `wb_sel`=3 and `inst_ok`=1.
- R5: Opcode 0100011 (store) gives `alu_use`=2, `mem_kind`=2, `opb_sel`=1, `wb_sel`=0 and `inst_ok`=1.
- R6: Opcode 0110111 (lui) gives only `wb_sel`=2 (the immediate) and `inst_ok`=1.
- R7: Opcode 0010111 (auipc) gives `alu_use`=2, `opa_pc`=1, `opb_sel`=1, `wb_sel`=1 and `inst_ok`=1.
- R8: Opcode 1100011 (conditional branch) gives `jump_kind`=3 and `inst_ok`=1, with every other field 0.
- R9: Opcode 1101111 (jal) gives `alu_use`=2, `jump_kind`=1, `opa_pc`=1, `opb_sel`=2 (constant 4) and `wb_sel`=1. Opcode 1100111 (jalr) gives the same values but with `jump_kind`=2. Both set `inst_ok`=1.
- R10: At most one instruction group matches any opcode, and `inst_ok` is 1 exactly when a group matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode | input | 7 | Major opcode, instruction bits 6:0 |
| alu_use | output | 2 | 0 no ALU, 1 arithmetic, 2 address/link/PC arithmetic |
| imm_arith | output | 1 | 1 for register-immediate arithmetic |
| word_op | output | 1 | 1 for a 32-bit (W) operation |
| jump_kind | output | 2 | 0 none, 1 jal, 2 jalr, 3 conditional branch |
| mem_kind | output | 2 | 0 none, 1 load, 2 store |
| opa_pc | output | 1 | ALU operand A: 0 register 1, 1 PC |
| opb_sel | output | 2 | ALU operand B: 0 register 2, 1 immediate, 2 constant 4 |
| wb_sel | output | 2 | 0 no write, 1 ALU, 2 immediate, 3 memory data |
| inst_ok | output | 1 | Opcode recognised |

## Verification
Two functions share one opcode in jal and jalr. For these, the ALU forms the link value PC+4 while the jump class redirects the PC. Loads and stores likewise use the ALU for an address while also requesting memory. The bench applies all 128 opcodes, so these overlapping rows appear next to their neighbours and next to undefined codes that differ by a single bit. Each response is compared as a whole against an expected word taken from the requirements, so a field that is set wrongly or left set where it should be zero is reported.

// File: rtl/rv64_main_decode.sv
module rv64_main_decode (
  input  logic [6:0] opcode,
  output logic [1:0] alu_use,
  output logic       imm_arith,
  output logic       word_op,
  output logic [1:0] jump_kind,
  output logic [1:0] mem_kind,
  output logic       opa_pc,
  output logic [1:0] opb_sel,
  output logic [1:0] wb_sel,
  output logic       inst_ok
);

  localparam logic [6:0] OPC_REG    = 7'b0110011;
  localparam logic [6:0] OPC_REGW   = 7'b0111011;
  localparam logic [6:0] OPC_IMM    = 7'b0010011;
  localparam logic [6:0] OPC_IMMW   = 7'b0011011;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_LUI    = 7'b0110111;
  localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;

  logic m_reg, m_regw, m_imm, m_immw, m_ld, m_st, m_lui, m_auipc, m_br, m_jal, m_jalr;

  assign m_reg   = (opcode == OPC_REG);
  assign m_regw  = (opcode == OPC_REGW);
  assign m_imm   = (opcode == OPC_IMM);
  assign m_immw  = (opcode == OPC_IMMW);
  assign m_ld    = (opcode == OPC_LOAD);
  assign m_st    = (opcode == OPC_STORE);
  assign m_lui   = (opcode == OPC_LUI);
  assign m_auipc = (opcode == OPC_AUIPC);
  assign m_br    = (opcode == OPC_BRANCH);
  assign m_jal   = (opcode == OPC_JAL);
  assign m_jalr  = (opcode == OPC_JALR);

  logic arith, addr_alu, link;
  assign arith    = m_reg | m_regw | m_imm | m_immw;
  assign link     = m_jal | m_jalr;
  assign addr_alu = m_ld | m_st | m_auipc | link;

  assign alu_use   = {addr_alu, arith};
  assign imm_arith = m_imm | m_immw;
  assign word_op   = m_regw | m_immw;
  assign jump_kind = {m_jalr | m_br, m_jal | m_br};
  assign mem_kind  = {m_st, m_ld};
  assign opa_pc    = m_auipc | link;
  assign opb_sel   = {link, m_imm | m_immw | m_ld | m_st | m_auipc};
  assign wb_sel    = {m_lui | m_ld, arith | m_auipc | link | m_ld};
  assign inst_ok   = arith | addr_alu | m_lui | m_br;

  always_comb begin
    if (!$isunknown(opcode)) begin
      assert_one_group_R10: assert ($onehot0({m_reg, m_regw, m_imm, m_immw, m_ld, m_st,
                                              m_lui, m_auipc, m_br, m_jal, m_jalr}));
      assert_invalid_silent_R1: assert (inst_ok || {alu_use, imm_arith, word_op, jump_kind,
                                        mem_kind, opa_pc, opb_sel, wb_sel} == 13'd0);
      assert_store_no_wb_R5: assert (mem_kind != 2'd2 || wb_sel == 2'd0);
      assert_load_mem_wb_R4: assert (mem_kind != 2'd1 || wb_sel == 2'd3);
      assert_link_const4_R9: assert (!(jump_kind == 2'd1 || jump_kind == 2'd2) ||
                                     (opb_sel == 2'd2 && opa_pc));
      assert_branch_bare_R8: assert (jump_kind != 2'd3 || (alu_use == 2'd0 && wb_sel == 2'd0));
      assert_pc_operand_R7: assert (!opa_pc || alu_use == 2'd2);
    end
  end

endmodule

// File: tb/rv64_main_decode_bench.sv
module rv64_main_decode_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [6:0] opcode;
  logic [1:0] alu_use, jump_kind, mem_kind, opb_sel, wb_sel;
  logic imm_arith, word_op, opa_pc, inst_ok;

  rv64_main_decode u_rv64_main_decode (
    .opcode(opcode), .alu_use(alu_use), .imm_arith(imm_arith), .word_op(word_op),
    .jump_kind(jump_kind), .mem_kind(mem_kind), .opa_pc(opa_pc), .opb_sel(opb_sel),
    .wb_sel(wb_sel), .inst_ok(inst_ok)
  );

  integer checks = 0;
  integer errors = 0;
  bit done = 0;

  // packing: alu2 arith1 word1 jump2 mem2 pc1 opb2 wb2 ok1
  function automatic logic [13:0] pack(input int a, input int ar, input int w, input int j,
                                       input int m, input int p, input int b, input int wb,
                                       input int ok);
    pack = {a[1:0], ar[0], w[0], j[1:0], m[1:0], p[0], b[1:0], wb[1:0], ok[0]};
  endfunction

  function automatic logic [13:0] expect_of(input logic [6:0] op);
    case (op)
      7'b0110011: return pack(1,0,0,0,0,0,0,1,1); // R2
      7'b0111011: return pack(1,0,1,0,0,0,0,1,1); // R2
      7'b0010011: return pack(1,1,0,0,0,0,1,1,1); // R3
      7'b0011011: return pack(1,1,1,0,0,0,1,1,1); // R3
      7'b0000011: return pack(2,0,0,0,1,0,1,3,1); // R4
      7'b0100011: return pack(2,0,0,0,2,0,1,0,1); // R5
      7'b0110111: return pack(0,0,0,0,0,0,0,2,1); // R6
      7'b0010111: return pack(2,0,0,0,0,1,1,1,1); // R7
      7'b1100011: return pack(0,0,0,3,0,0,0,0,1); // R8
      7'b1101111: return pack(2,0,0,1,0,1,2,1,1); // R9
      7'b1100111: return pack(2,0,0,2,0,1,2,1,1); // R9
      default:    return 14'd0;                   // R1
    endcase
  endfunction

  function automatic string req_of(input logic [6:0] op);
    case (op)
      7'b0110011, 7'b0111011: return "R2";
      7'b0010011, 7'b0011011: return "R3";
      7'b0000011: return "R4";
      7'b0100011: return "R5";
      7'b0110111: return "R6";
      7'b0010111: return "R7";
      7'b1100011: return "R8";
      7'b1101111, 7'b1100111: return "R9";
      default:    return "R1";
    endcase
  endfunction

  task automatic check_now(input string tag);
    logic [13:0] got, exp;
    got = {alu_use, imm_arith, word_op, jump_kind, mem_kind, opa_pc, opb_sel, wb_sel, inst_ok};
    exp = expect_of(opcode);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s opcode=%b actual=%b expected=%b", tag, opcode, got, exp);
    end
    checks++; // R10: valid flag against membership in the decoded set
    if (inst_ok !== (exp != 14'd0)) begin
      errors++;
      $display("FAIL R10 opcode=%b actual=%b expected=%b", opcode, inst_ok, exp != 14'd0);
    end
  endtask

  initial begin
    opcode = 7'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_now("R1 reset-state");
    rst = 1'b0;
    for (int i = 0; i < 128; i++) begin
      @(posedge clk);
      opcode = i[6:0];
      @(negedge clk);
      check_now(req_of(opcode));
    end
    // walk single-bit neighbours of the jump opcodes (R1 vs R9)
    for (int k = 0; k < 7; k++) begin
      @(posedge clk);
      opcode = 7'b1101111 ^ (7'd1 << k);
      @(negedge clk);
      check_now(req_of(opcode));
    end
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule